// File: doc/BRIEF.md
# Predicated Vector Subtractor with Carry Mask

This block subtracts one 256-bit vector operand from another, lane by lane, and registers the difference one clock later. Lanes are 8, 16 or 32 bits wide, chosen per operation. A per-byte predicate decides which lanes take part. Lanes that are switched off either keep the previous destination contents, which the caller supplies, or are cleared to zero. The choice depends on a mode input.

Alongside the difference, the block returns a per-byte carry mask. For each active lane it holds the carry-out of `a + ~b + 1`. That bit is 1 when the lane did not need a borrow and 0 when it did. It is written into the lowest mask bit of that lane's byte group. The borrow test treats the raw bit patterns as unsigned values for signed and unsigned data alike. Results wrap modulo 2^width. There is no saturation and no overflow flag.

Top module: `pvsub_top`

## Requirements
- R1: The element size is selected by `esize_i`: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Each active lane of `dst_o` holds `src_a - src_b` wrapped modulo 2^width. Lane l occupies bits `[l*W +: W]`.
- R2: An active lane's carry bit is 1 when `src_a >= src_b` as unsigned bit patterns, and 0 otherwise. For example, in a 32-bit lane, 5-2 gives 3 with carry 1, 5-(-7) gives 12 with carry 0, and 5-7 gives 0xFFFFFFFE with carry 0.
- R3: The carry bit of a lane spanning bytes `[l*N, l*N+N-1]` is placed at `carry_o[l*N]`. The other N-1 bits of the group are 0.
- R4: A lane is active when `pred_i[l*N]` is 1. The other predicate bits inside the group have no effect.
- R5: When `merge_i` is 0, every byte of an inactive lane in `dst_o` is 0.
- R6: When `merge_i` is 1, every byte of an inactive lane in `dst_o` equals the same byte of `dst_prev_i`.
- R7: The carry-mask bits of inactive lanes are 0 in both modes.
- R8: `esize_i` = 3 is reserved and yields an all-zero `dst_o` and `carry_o`.
- R9: The results appear on the clock edge after the edge that samples `valid_i` = 1. On that edge `valid_o` goes to 1 for one cycle. While `valid_i` is 0, `dst_o` and `carry_o` hold their values.
- R10: While `rst_ni` is low, `valid_o`, `dst_o` and `carry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| src_a_i | input | 256 | Minuend vector |
| src_b_i | input | 256 | Subtrahend vector |
| dst_prev_i | input | 256 | Prior destination contents, used for merging |
| pred_i | input | 32 | Per-byte predicate |
| esize_i | input | 2 | Element size select (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved) |
| merge_i | input | 1 | 1: inactive lanes keep the prior value, 0: inactive lanes are zeroed |
| valid_o | output | 1 | Result valid |
| dst_o | output | 256 | Difference vector |
| carry_o | output | 32 | Inverted-borrow mask |

## Verification
A wrong borrow-chain boundary would corrupt a 16- or 32-bit lane, or a wrong lane-base decode would place a carry at a non-lowest bit of its group. Either fault shows in `dst_o` or `carry_o` on the very cycle after the request. Directed cases cover operands that are equal, borrowing and non-borrowing, as well as predicates set only on non-base bytes. A stale or badly gated register shows up as a changed output while `valid_i` is low, one cycle after the input change.

// File: rtl/pvsub_pkg.sv
package pvsub_pkg;
  typedef enum logic [1:0] {
    ESZ_8   = 2'd0,
    ESZ_16  = 2'd1,
    ESZ_32  = 2'd2,
    ESZ_RSV = 2'd3
  } esize_e;
endpackage

// File: rtl/pvsub_borrow_chain.sv
module pvsub_borrow_chain
  import pvsub_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  esize_e           esize_i,
  output logic [VEC_W-1:0] diff_o,
  output logic [NB-1:0]    cout_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam bit BASE16 = (k % 2) == 0;
    localparam bit BASE32 = (k % 4) == 0;
    logic start;
    logic cin;
    logic [8:0] sum;

    always_comb begin
      case (esize_i)
        ESZ_16:  start = BASE16;
        ESZ_32:  start = BASE32;
        default: start = 1'b1;
      endcase
    end

    // lane start injects the +1 of two's complement; otherwise ripple
    if (k == 0) begin : g_first
      assign cin = 1'b1;
    end else begin : g_rest
      assign cin = start ? 1'b1 : cout_o[k-1];
    end

    assign sum = {1'b0, a_i[k*8 +: 8]} + {1'b0, ~b_i[k*8 +: 8]} + {8'b0, cin};
    assign diff_o[k*8 +: 8] = sum[7:0];
    assign cout_o[k] = sum[8];
  end
endmodule

// File: rtl/pvsub_lane_sel.sv
module pvsub_lane_sel
  import pvsub_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic [VEC_W-1:0] diff_i,
  input  logic [NB-1:0]    cout_i,
  input  logic [VEC_W-1:0] prev_i,
  input  logic [NB-1:0]    pred_i,
  input  esize_e           esize_i,
  input  logic             merge_i,
  output logic [VEC_W-1:0] dst_o,
  output logic [NB-1:0]    carry_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam int unsigned B16 = k & ~1;
    localparam int unsigned B32 = k & ~3;
    localparam int unsigned T16 = k | 1;
    localparam int unsigned T32 = k | 3;
    logic act, is_base, top_c, rsv;

    always_comb begin
      rsv = 1'b0;
      case (esize_i)
        ESZ_8: begin
          act = pred_i[k]; top_c = cout_i[k]; is_base = 1'b1;
        end
        ESZ_16: begin
          act = pred_i[B16]; top_c = cout_i[T16]; is_base = (B16 == k);
        end
        ESZ_32: begin
          act = pred_i[B32]; top_c = cout_i[T32]; is_base = (B32 == k);
        end
        default: begin
          act = 1'b0; top_c = 1'b0; is_base = 1'b0; rsv = 1'b1;
        end
      endcase
    end

    always_comb begin
      if (act)                dst_o[k*8 +: 8] = diff_i[k*8 +: 8];
      else if (merge_i && !rsv) dst_o[k*8 +: 8] = prev_i[k*8 +: 8];
      else                    dst_o[k*8 +: 8] = 8'h00;
    end

    assign carry_o[k] = act & is_base & top_c;
  end
endmodule

// File: rtl/pvsub_top.sv
module pvsub_top
  import pvsub_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned NB   = VEC_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] dst_prev_i,
  input  logic [NB-1:0]    pred_i,
  input  logic [1:0]       esize_i,
  input  logic             merge_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] dst_o,
  output logic [NB-1:0]    carry_o
);
  esize_e           esz;
  logic [VEC_W-1:0] diff, dst_d;
  logic [NB-1:0]    cout, carry_d;

  assign esz = esize_e'(esize_i);

  pvsub_borrow_chain #(.VEC_W(VEC_W)) u_chain (
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .esize_i (esz),
    .diff_o  (diff),
    .cout_o  (cout)
  );

  pvsub_lane_sel #(.VEC_W(VEC_W)) u_sel (
    .diff_i  (diff),
    .cout_i  (cout),
    .prev_i  (dst_prev_i),
    .pred_i  (pred_i),
    .esize_i (esz),
    .merge_i (merge_i),
    .dst_o   (dst_d),
    .carry_o (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
      carry_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o   <= dst_d;
        carry_o <= carry_d;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o) && $stable(carry_o));
  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && esize_i == 2'd3 |=> dst_o == '0 && carry_o == '0);
  a_r3_carry_pos32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && esize_i == 2'd2 |=> (carry_o & {(NB/4){4'b1110}}) == '0);
  a_r3_carry_pos16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && esize_i == 2'd1 |=> (carry_o & {(NB/2){2'b10}}) == '0);
  a_r7_inactive_carry8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && esize_i == 2'd0 |=> (carry_o & ~$past(pred_i)) == '0);
endmodule

// File: tb/pvsub_top_test.sv
module pvsub_top_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [255:0] src_a_i = '0, src_b_i = '0, dst_prev_i = '0;
  logic [31:0]  pred_i = '0;
  logic [1:0]   esize_i = '0;
  logic         merge_i = 1'b0;
  logic         valid_o;
  logic [255:0] dst_o;
  logic [31:0]  carry_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pvsub_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dst_prev_i(dst_prev_i), .pred_i(pred_i),
    .esize_i(esize_i), .merge_i(merge_i), .valid_o(valid_o),
    .dst_o(dst_o), .carry_o(carry_o)
  );

  function automatic void ref_model(input logic [255:0] a, input logic [255:0] b,
                                    input logic [255:0] prev, input logic [31:0] pred,
                                    input logic [1:0] esz, input logic merge,
                                    output logic [255:0] d, output logic [31:0] c);
    int nb;
    d = '0; c = '0;
    if (esz == 2'd3) return;
    nb = 1 << esz;
    for (int l = 0; l < 32 / nb; l++) begin
      logic [31:0] x, y, r;
      x = '0; y = '0;
      for (int j = 0; j < nb; j++) begin
        x[j*8 +: 8] = a[(l*nb+j)*8 +: 8];
        y[j*8 +: 8] = b[(l*nb+j)*8 +: 8];
      end
      r = x - y;
      if (pred[l*nb]) begin
        c[l*nb] = (x >= y);
        for (int j = 0; j < nb; j++) d[(l*nb+j)*8 +: 8] = r[j*8 +: 8];
      end else if (merge) begin
        for (int j = 0; j < nb; j++) d[(l*nb+j)*8 +: 8] = prev[(l*nb+j)*8 +: 8];
      end
    end
  endfunction

  task automatic check_eq(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [255:0] a, input logic [255:0] b, input logic [255:0] prev,
                        input logic [31:0] pred, input logic [1:0] esz, input logic merge,
                        input string tag);
    logic [255:0] ed;
    logic [31:0]  ec;
    ref_model(a, b, prev, pred, esz, merge, ed, ec);
    @(negedge clk);
    src_a_i = a; src_b_i = b; dst_prev_i = prev; pred_i = pred;
    esize_i = esz; merge_i = merge; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check_eq({tag, " R9 valid"}, {255'b0, valid_o}, 256'd1);
    check_eq({tag, " dst"}, dst_o, ed);
    check_eq({tag, " carry"}, {224'b0, carry_o}, {224'b0, ec});
  endtask

  function automatic logic [255:0] rnd_vec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] a, b, hold_d;
    logic [31:0]  hold_c;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R10 reset state
    check_eq("R10 valid", {255'b0, valid_o}, '0);
    check_eq("R10 dst", dst_o, '0);
    check_eq("R10 carry", {224'b0, carry_o}, '0);
    rst_ni = 1'b1;

    // R1 R2 32-bit: lane0 5-2, lane1 5-(-7), lane2 5-7, lane3 equal
    a = '0; b = '0;
    a[31:0] = 32'd5;  b[31:0] = 32'd2;
    a[63:32] = 32'd5; b[63:32] = 32'hFFFF_FFF9;
    a[95:64] = 32'd5; b[95:64] = 32'd7;
    a[127:96] = 32'h1234_5678; b[127:96] = 32'h1234_5678;
    run_op(a, b, '0, 32'hFFFF_FFFF, 2'd2, 1'b0, "R1 R2 R3 int32");
    check_eq("R2 5-2", {224'b0, dst_o[31:0]}, 256'd3);
    check_eq("R2 5-(-7)", {224'b0, dst_o[63:32]}, 256'd12);
    check_eq("R2 5-7", {224'b0, dst_o[95:64]}, {224'b0, 32'hFFFF_FFFE});
    check_eq("R3 carry bits", {224'b0, carry_o[15:0]}, {240'b0, 16'h1001});

    // R4 only non-base predicate bits set in 32-bit lanes
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'hEEEE_EEEE, 2'd2, 1'b0, "R4 R5 nonbase pred");
    check_eq("R4 zero out", dst_o, '0);
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'hAAAA_AAAA, 2'd1, 1'b1, "R4 R6 nonbase pred16");
    // R5/R6/R7 mixed predicates
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'h0F0F_3355, 2'd0, 1'b0, "R5 R7 zeroing");
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'h0F0F_3355, 2'd0, 1'b1, "R6 R7 merging");
    // 16-bit borrow across byte boundary: 0x0100 - 0x0001
    a = '0; b = '0; a[15:0] = 16'h0100; b[15:0] = 16'h0001;
    run_op(a, b, '0, 32'h0000_0001, 2'd1, 1'b0, "R1 R2 int16 ripple");
    check_eq("R1 ripple", {240'b0, dst_o[15:0]}, {240'b0, 16'h00FF});
    // R8 reserved
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'hFFFF_FFFF, 2'd3, 1'b1, "R8 reserved");

    // R9 hold while idle
    hold_d = dst_o; hold_c = carry_o;
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), $urandom, 2'd2, 1'b1, "R9 setup");
    hold_d = dst_o; hold_c = carry_o;
    @(negedge clk);
    src_a_i = rnd_vec(); src_b_i = rnd_vec(); pred_i = '1; esize_i = 2'd0;
    @(negedge clk);
    check_eq("R9 idle valid", {255'b0, valid_o}, '0);
    check_eq("R9 hold dst", dst_o, hold_d);
    check_eq("R9 hold carry", {224'b0, carry_o}, {224'b0, hold_c});

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [255:0] ra, rb;
      ra = rnd_vec();
      rb = ($urandom % 4 == 0) ? ra : rnd_vec();
      run_op(ra, rb, rnd_vec(), $urandom, 2'($urandom % 4), 1'($urandom),
             "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule